// File: doc/BRIEF.md
# PTP Correction Field Updater

A streaming byte-path stage for the egress side of a one-step end-to-end transparent clock. Frame bytes enter one per cycle with a start-of-frame marker. Side inputs describe the frame: where its PTP header begins, the PTP message type, the egress timestamp, a per-port delay asymmetry and the position of a reserved header byte. The block rewrites the 64-bit correctionField found at header bytes 8 through 15 and passes every other byte through untouched.

The new correctionField is the old one plus three terms. The first is the egress nanoseconds. The second is one second for each step of seconds rollover. That count is found by taking the low four bits of the ingress seconds, carried in the reserved header byte, away from the low four bits of the egress seconds, modulo 16. The third term applies only to delay-request type messages: the asymmetry is subtracted. The nanosecond terms are put into the field's 2^-16 ns unit before they are summed. The sum is clamped at the largest positive value. A field that already holds that value is left as it is.

The whole 64-bit field has to be known before its first byte can leave. For this reason the stream is held in a fixed eight-cycle delay line. Bytes of one frame must arrive on consecutive cycles.

Top module: `ptpcf_updater`

## Requirements
- R1: Every byte that is not a correctionField byte of a rewritten frame leaves the block with the value it entered with.
- R2: Each input cycle appears at the output exactly 8 clock cycles later, with valid and start-of-frame (start-of-frame counts only together with valid) kept. After reset the output is idle.
- R3: A frame is rewritten when `corr_en` is 1 and `msg_type` is below 4. The rewrite replaces header bytes 8..15 (header byte n is frame byte `hdr_off`+n) with the new 64-bit value, most significant byte first. Negative fields are handled as two's complement.
- R4: The egress nanoseconds, multiplied by 65536, are added to the correctionField.
- R5: The ingress seconds hint is bits 3:0 of header byte `rsvd_off`, which must lie in 2..7. The value (`egr_sec_lo` − hint) mod 16, times 10^9 ns and times 65536, is added to the field.
- R6: `asym`×65536 is subtracted only when `asym_en` is 1 and `msg_type` is 1 (delay request) or 2 (peer delay request).
- R7: An incoming correctionField of 0x7FFFFFFFFFFFFFFF is sent out unchanged.
- R8: A result above 0x7FFFFFFFFFFFFFFF is replaced by 0x7FFFFFFFFFFFFFFF. The test is made after the asymmetry subtraction.
- R9: `hdr_off`, `rsvd_off`, `msg_type`, `corr_en`, `asym_en`, `asym`, `egr_ns` and `egr_sec_lo` are sampled on the start-of-frame byte. Later changes have no effect on that frame.
- R10: With `corr_en` at 0, or with `msg_type` 4 or above, the correctionField bytes pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present |
| in_sof | input | 1 | First byte of a frame |
| in_data | input | DW (8) | Input byte |
| hdr_off | input | OFF_W (8) | Frame byte index of PTP header byte 0 |
| msg_type | input | 4 | PTP messageType of the frame |
| egr_sec_lo | input | HINT_W (4) | Low bits of the egress seconds |
| egr_ns | input | NS_W (32) | Egress nanoseconds |
| asym | input | ASYM_W (16) | Port delay asymmetry, ns |
| rsvd_off | input | ROFF_W (6) | Header byte index of the ingress seconds hint |
| corr_en | input | 1 | Enable correctionField rewrite |
| asym_en | input | 1 | Enable asymmetry subtraction |
| out_valid | output | 1 | Output byte present |
| out_sof | output | 1 | First output byte of a frame |
| out_data | output | DW (8) | Output byte |

## Verification
The hardest cases to reach are at the top of the range, where the order of the operations decides the result. One is a field one below the maximum with the asymmetry taken off, which must land under the clamp and not on it. Another is a field a few units below the maximum that is pushed over it. The bench builds frames with these exact correctionField values, together with a hint that is larger than the egress seconds so that the modulo-16 rollover is taken. It also changes every side input right after the start-of-frame byte, to show that only the sampled values count.

// File: rtl/ptpcf_pkg.sv
package ptpcf_pkg;
   localparam int unsigned CF_W      = 64;
   localparam int unsigned CF_BYTES  = CF_W / 8;
   localparam int unsigned CF_HDR_AT = 8;
   localparam int unsigned FRAC_BITS = 16;
   localparam logic [CF_W-1:0] CF_MAX = {1'b0, {(CF_W-1){1'b1}}};

   typedef enum logic [3:0] {
      MT_SYNC      = 4'd0,
      MT_DLY_REQ   = 4'd1,
      MT_PDLY_REQ  = 4'd2,
      MT_PDLY_RESP = 4'd3
   } ptp_evt_e;

   function automatic logic is_event(input logic [3:0] t);
      return t <= MT_PDLY_RESP;
   endfunction

   function automatic logic takes_asym(input logic [3:0] t);
      return (t == MT_DLY_REQ) || (t == MT_PDLY_REQ);
   endfunction
endpackage

// File: rtl/ptpcf_delay.sv
module ptpcf_delay #(
   parameter int W     = 8,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("ptpcf_delay: DEPTH must be at least 2");
      end
   endgenerate

   logic [DEPTH-1:0][W-1:0] stg;

   always_ff @(posedge clk) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[DEPTH-2:0], d};
   end

   assign q = stg[DEPTH-1];
endmodule

// File: rtl/ptpcf_hdr_track.sv
module ptpcf_hdr_track
   import ptpcf_pkg::*;
#(
   parameter int DW     = 8,
   parameter int POS_W  = 12,
   parameter int OFF_W  = 8,
   parameter int ROFF_W = 6,
   parameter int HINT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sof,
   input  logic [DW-1:0]     in_data,
   input  logic [OFF_W-1:0]  hdr_off,
   input  logic [ROFF_W-1:0] rsvd_off,
   output logic [CF_W-1:0]   cf_q,
   output logic [HINT_W-1:0] hint_q,
   output logic              tag_v,
   output logic [2:0]        tag_idx
);
   generate
      if (OFF_W > POS_W || ROFF_W > POS_W) begin : g_bad_w
         $error("ptpcf_hdr_track: offsets wider than position counter");
      end
      if (HINT_W > DW) begin : g_bad_hint
         $error("ptpcf_hdr_track: hint wider than a byte");
      end
   endgenerate

   logic              sof_v;
   logic [POS_W-1:0]  pos_q, cur_pos, hidx;
   logic [OFF_W-1:0]  off_q, cur_off;
   logic [ROFF_W-1:0] roff_q, cur_roff;
   logic              in_hdr, hint_hit;

   always_comb begin
      sof_v    = in_valid && in_sof;
      cur_pos  = sof_v ? '0 : pos_q;
      cur_off  = sof_v ? hdr_off : off_q;
      cur_roff = sof_v ? rsvd_off : roff_q;
      in_hdr   = cur_pos >= POS_W'(cur_off);
      hidx     = cur_pos - POS_W'(cur_off);
      tag_v    = in_valid && in_hdr &&
                 (hidx >= POS_W'(CF_HDR_AT)) && (hidx < POS_W'(CF_HDR_AT + CF_BYTES));
      tag_idx  = hidx[2:0];
      hint_hit = in_valid && in_hdr && (hidx == POS_W'(cur_roff));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q  <= '0;
         off_q  <= '0;
         roff_q <= '0;
         cf_q   <= '0;
         hint_q <= '0;
      end else begin
         if (in_valid && cur_pos != '1) pos_q <= cur_pos + 1'b1;
         if (sof_v) begin
            off_q  <= hdr_off;
            roff_q <= rsvd_off;
         end
         if (tag_v)    cf_q   <= {cf_q[CF_W-DW-1:0], in_data};
         if (hint_hit) hint_q <= in_data[HINT_W-1:0];
      end
   end

   // R3: field bytes are seen in order, one per cycle
   p_cf_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tag_v && tag_idx != 3'd0) |-> ($past(tag_v) && tag_idx == $past(tag_idx) + 3'd1));
endmodule

// File: rtl/ptpcf_calc.sv
module ptpcf_calc
   import ptpcf_pkg::*;
#(
   parameter int NS_W     = 32,
   parameter int ASYM_W   = 16,
   parameter int HINT_W   = 4,
   parameter int NS_PER_S = 1_000_000_000
) (
   input  logic [CF_W-1:0]   cf,
   input  logic [HINT_W-1:0] hint,
   input  logic [HINT_W-1:0] egr_sec,
   input  logic [NS_W-1:0]   egr_ns,
   input  logic [ASYM_W-1:0] asym,
   input  logic              asym_on,
   output logic [CF_W-1:0]   res
);
   localparam int TERM_W = NS_W + HINT_W;
   localparam int ACC_W  = CF_W + 2;

   generate
      if (TERM_W + FRAC_BITS >= CF_W || ASYM_W + FRAC_BITS >= CF_W) begin : g_bad_w
         $error("ptpcf_calc: terms too wide for the accumulator");
      end
   endgenerate

   logic [HINT_W-1:0] dsec;
   logic [TERM_W-1:0] ns_tot;
   logic [ACC_W-1:0]  acc, add_t, sub_t;
   logic              over;

   always_comb begin
      dsec   = egr_sec - hint;
      ns_tot = TERM_W'(egr_ns) + TERM_W'(dsec) * TERM_W'(NS_PER_S);
      add_t  = ACC_W'({ns_tot, {FRAC_BITS{1'b0}}});
      sub_t  = asym_on ? ACC_W'({asym, {FRAC_BITS{1'b0}}}) : '0;
      acc    = {{(ACC_W-CF_W){cf[CF_W-1]}}, cf} + add_t - sub_t;
      over   = !acc[ACC_W-1] && (acc[ACC_W-2:CF_W-1] != '0);
      res    = (cf == CF_MAX || over) ? CF_MAX : acc[CF_W-1:0];
   end
endmodule

// File: rtl/ptpcf_updater.sv
module ptpcf_updater
   import ptpcf_pkg::*;
#(
   parameter int DW       = 8,
   parameter int POS_W    = 12,
   parameter int OFF_W    = 8,
   parameter int ROFF_W   = 6,
   parameter int NS_W     = 32,
   parameter int ASYM_W   = 16,
   parameter int HINT_W   = 4,
   parameter int NS_PER_S = 1_000_000_000,
   parameter int DLY      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sof,
   input  logic [DW-1:0]     in_data,
   input  logic [OFF_W-1:0]  hdr_off,
   input  logic [3:0]        msg_type,
   input  logic [HINT_W-1:0] egr_sec_lo,
   input  logic [NS_W-1:0]   egr_ns,
   input  logic [ASYM_W-1:0] asym,
   input  logic [ROFF_W-1:0] rsvd_off,
   input  logic              corr_en,
   input  logic              asym_en,
   output logic              out_valid,
   output logic              out_sof,
   output logic [DW-1:0]     out_data
);
   localparam int LW    = 2 + DW + 1 + 3;
   localparam int WRM_W = $clog2(DLY + 1);

   generate
      if (DW != 8) begin : g_bad_dw
         $error("ptpcf_updater: byte path must be 8 bits");
      end
      if (DLY != CF_BYTES) begin : g_bad_dly
         $error("ptpcf_updater: delay must equal the field length in bytes");
      end
   endgenerate

   // header tracking and field capture
   logic [CF_W-1:0]   cf_q;
   logic [HINT_W-1:0] hint_q;
   logic              trk_v;
   logic [2:0]        trk_idx;

   ptpcf_hdr_track #(.DW(DW), .POS_W(POS_W), .OFF_W(OFF_W), .ROFF_W(ROFF_W), .HINT_W(HINT_W)) u_trk (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
      .hdr_off(hdr_off), .rsvd_off(rsvd_off), .cf_q(cf_q), .hint_q(hint_q),
      .tag_v(trk_v), .tag_idx(trk_idx));

   // per-frame side inputs, sampled on the first byte
   logic              sof_v;
   logic              rw_q, asym_on_q;
   logic [NS_W-1:0]   ns_q;
   logic [HINT_W-1:0] sec_q;
   logic [ASYM_W-1:0] asym_q;

   assign sof_v = in_valid && in_sof;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rw_q      <= 1'b0;
         asym_on_q <= 1'b0;
         ns_q      <= '0;
         sec_q     <= '0;
         asym_q    <= '0;
      end else if (sof_v) begin
         rw_q      <= corr_en && is_event(msg_type);
         asym_on_q <= asym_en && takes_asym(msg_type);
         ns_q      <= egr_ns;
         sec_q     <= egr_sec_lo;
         asym_q    <= asym;
      end
   end

   // new field value
   logic [CF_W-1:0] res;

   ptpcf_calc #(.NS_W(NS_W), .ASYM_W(ASYM_W), .HINT_W(HINT_W), .NS_PER_S(NS_PER_S)) u_calc (
      .cf(cf_q), .hint(hint_q), .egr_sec(sec_q), .egr_ns(ns_q), .asym(asym_q),
      .asym_on(asym_on_q), .res(res));

   // fixed delay line
   logic [LW-1:0] line_in, line_out;
   logic          o_tag_v;
   logic [2:0]    o_idx;
   logic [DW-1:0] o_data;

   assign line_in = {in_valid, sof_v, in_data, trk_v, trk_idx};

   ptpcf_delay #(.W(LW), .DEPTH(DLY)) u_dly (
      .clk(clk), .rst_n(rst_n), .d(line_in), .q(line_out));

   assign {out_valid, out_sof, o_data, o_tag_v, o_idx} = line_out;

   always_comb begin
      out_data = o_data;
      if (o_tag_v && rw_q) out_data = res[{3'd7 - o_idx, 3'b000} +: 8];
   end

   // assertion support: cycles since reset release
   logic [WRM_W-1:0] warm_q;
   always_ff @(posedge clk) begin
      if (!rst_n)                    warm_q <= '0;
      else if (warm_q != WRM_W'(DLY)) warm_q <= warm_q + 1'b1;
   end

   p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q == WRM_W'(DLY)) |->
         (out_valid == $past(in_valid, 8) && out_sof == $past(in_valid && in_sof, 8)));

   p_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q == WRM_W'(DLY) && !o_tag_v) |-> (out_data == $past(in_data, 8)));

   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!asym_on_q && !cf_q[CF_W-1]) |-> !res[CF_W-1]);

   p_grow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!asym_on_q && !cf_q[CF_W-1]) |-> (res >= cf_q));

   p_rsvd_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sof_v && corr_en) |-> (rsvd_off >= ROFF_W'(2) && rsvd_off <= ROFF_W'(7)));
endmodule

// File: tb/sim_ptpcf_updater.sv
module sim_ptpcf_updater;
   localparam logic [63:0] MAXV = 64'h7FFF_FFFF_FFFF_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_sof = 1'b0;
   logic [7:0]  in_data = '0, hdr_off = '0;
   logic [3:0]  msg_type = '0, egr_sec_lo = '0;
   logic [31:0] egr_ns = '0;
   logic [15:0] asym = '0;
   logic [5:0]  rsvd_off = 6'd5;
   logic        corr_en = 1'b0, asym_en = 1'b0;
   logic        out_valid, out_sof;
   logic [7:0]  out_data;

   ptpcf_updater u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
      .hdr_off(hdr_off), .msg_type(msg_type), .egr_sec_lo(egr_sec_lo), .egr_ns(egr_ns),
      .asym(asym), .rsvd_off(rsvd_off), .corr_en(corr_en), .asym_en(asym_en),
      .out_valid(out_valid), .out_sof(out_sof), .out_data(out_data));

   always #5 clk = ~clk;

   int    n_chk = 0, n_fail = 0, cyc = 0;
   bit    done = 1'b0;
   logic [8:0] exp_q[$];
   string      req_q[$];
   int         sofc_q[$];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // requirement model (R4 R5 R6 R7 R8)
   function automatic logic [63:0] model(input logic [63:0] cf, input logic [3:0] hint,
      input logic [3:0] esec, input logic [31:0] ens, input logic [15:0] as, input bit sub);
      logic [3:0] ds;
      logic signed [71:0] a, t;
      if (cf == MAXV) return MAXV;
      ds = esec - hint;
      t  = 72'(ens) + 72'(ds) * 72'd1000000000;
      a  = {{8{cf[63]}}, cf} + t * 72'sd65536;
      if (sub) a = a - 72'(as) * 72'sd65536;
      if (a > 72'sh7FFF_FFFF_FFFF_FFFF) return MAXV;
      return a[63:0];
   endfunction

   task automatic send_frame(input int hoff, input int roff, input logic [3:0] mt,
      input bit ce, input bit ae, input logic [63:0] cf, input logic [3:0] hint,
      input logic [3:0] esec, input logic [31:0] ens, input logic [15:0] as,
      input string req, input bit scramble, input int gap);
      logic [63:0] ncf;
      logic [7:0]  b;
      int          len;
      bit          rw;
      len = hoff + 44;
      rw  = ce && (mt < 4);
      ncf = rw ? model(cf, hint, esec, ens, as, ae && (mt == 1 || mt == 2)) : cf;
      msg_type = mt; corr_en = ce; asym_en = ae; egr_sec_lo = esec; egr_ns = ens;
      asym = as; hdr_off = 8'(hoff); rsvd_off = 6'(roff);
      for (int i = 0; i < len; i++) begin
         int h;
         h = i - hoff;
         if (i < hoff)                b = 8'(i * 7 + 3);
         else if (h == roff)          b = {4'hA, hint};
         else if (h >= 8 && h < 16)   b = cf[8*(15-h) +: 8];
         else                         b = 8'(i) ^ 8'h5C;
         in_valid = 1'b1; in_sof = (i == 0); in_data = b;
         if (i >= hoff && h >= 8 && h < 16) begin
            exp_q.push_back({i == 0, ncf[8*(15-h) +: 8]});
            req_q.push_back(req);
         end else begin
            exp_q.push_back({i == 0, b});
            req_q.push_back("R1");
         end
         if (i == 0) sofc_q.push_back(cyc);
         @(posedge clk); #1;
         if (i == 0 && scramble) begin
            // R9: changes after the first byte must not matter
            egr_ns = ~ens; asym = ~as; msg_type = 4'hF; corr_en = ~ce; asym_en = ~ae;
            egr_sec_lo = ~esec; hdr_off = 8'(hoff + 3); rsvd_off = 6'(roff + 1);
         end
      end
      in_valid = 1'b0; in_sof = 1'b0;
      repeat (gap) begin @(posedge clk); #1; end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && !done && out_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R2 unexpected byte", {55'd0, out_sof, out_data}, 64'd0);
         end else begin
            logic [8:0] e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            check({out_sof, out_data} == e, r, {55'd0, out_sof, out_data}, {55'd0, e});
            if (out_sof && sofc_q.size() != 0) begin
               int s;
               s = sofc_q.pop_front();
               check(cyc - s == 8, "R2 latency", 64'(cyc - s), 64'd8);
            end
         end
      end
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL R2 watchdog expired actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(out_valid == 1'b0 && out_sof == 1'b0, "R2 idle after reset", {62'd0, out_valid, out_sof}, 64'd0);
      @(posedge clk); #1;
      // R4: sync, plain add with small rollover (asym_en ignored for sync, R6)
      send_frame(14, 5, 4'd0, 1, 1, 64'h0000_0001_0000_8000, 4'd3, 4'd5, 32'd123456789, 16'd300, "R4", 0, 4);
      // R6: delay request subtracts asymmetry
      send_frame(14, 5, 4'd1, 1, 1, 64'h0000_0100_0000_0000, 4'd9, 4'd9, 32'd1000, 16'd500, "R6", 0, 4);
      // R6: peer delay request with subtraction disabled
      send_frame(14, 5, 4'd2, 1, 0, 64'h0000_0100_0000_0000, 4'd9, 4'd9, 32'd1000, 16'd700, "R6", 0, 4);
      // R5: hint above egress seconds, wraps to 3 s, hint at byte 7
      send_frame(42, 7, 4'd3, 1, 0, 64'h0000_0000_1234_5678, 4'd14, 4'd1, 32'd999999999, 16'd0, "R5", 0, 4);
      // R7: maximum passes through
      send_frame(14, 5, 4'd0, 1, 0, MAXV, 4'd0, 4'd7, 32'd5000, 16'd0, "R7", 0, 4);
      // R8: pushed over the maximum
      send_frame(14, 5, 4'd0, 1, 0, MAXV - 64'd5, 4'd2, 4'd2, 32'd1, 16'd0, "R8", 0, 4);
      // R8: subtraction before the clamp keeps it below the maximum
      send_frame(14, 5, 4'd1, 1, 1, MAXV - 64'd1, 4'd4, 4'd4, 32'd0, 16'd100, "R8", 0, 4);
      // R10: rewrite disabled
      send_frame(14, 5, 4'd0, 0, 1, 64'h0000_0002_0000_0000, 4'd1, 4'd6, 32'd777, 16'd9, "R10", 0, 4);
      // R10: non-event message type
      send_frame(14, 5, 4'd8, 1, 1, 64'h0000_0002_0000_0000, 4'd1, 4'd6, 32'd777, 16'd9, "R10", 0, 4);
      // R9: side inputs change after first byte; header at frame byte 0
      send_frame(0, 2, 4'd2, 1, 1, 64'h0000_0000_0001_0000, 4'd15, 4'd0, 32'd4242, 16'd65535, "R9", 1, 4);
      // R3: negative field, full asymmetry, back-to-back frames
      send_frame(14, 6, 4'd1, 1, 1, 64'hFFFF_FFFF_0000_0000, 4'd0, 4'd0, 32'd10, 16'd65535, "R3", 0, 0);
      send_frame(20, 3, 4'd0, 1, 0, 64'h0123_4567_89AB_CDEF, 4'd5, 4'd4, 32'hFFFF_FFFF, 16'd0, "R3", 0, 0);
      send_frame(14, 5, 4'd2, 1, 1, 64'h7000_0000_0000_0000, 4'd8, 4'd7, 32'd3, 16'd1, "R8", 0, 12);
      repeat (20) @(posedge clk);
      @(negedge clk);
      check(exp_q.size() == 0, "R2 all bytes delivered", 64'(exp_q.size()), 64'd0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule